// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block stores the two thresholds that a FIFO uses for its partial-level warnings and turns the FIFO's occupancy count into an almost-empty flag and an almost-full flag. One threshold sets how few words count as "almost empty". The other sets how little free space counts as "almost full". The occupancy count comes from the FIFO core and is already in this block's clock domain. The flags are registered, so each one follows the count by one clock.

There are three ways to set the thresholds:

- **Reset defaults.** A master reset loads one of two parameterized defaults into both thresholds. A select input chooses which default.
- **Serial load.** A serial-enable input shifts in one bit per clock. The serial data input does double duty: during master reset it is captured as the FIFO's timing-mode select. After reset it carries threshold bits.
- **Parallel load.** The load control writes the thresholds from the data bus, one per write. With load high and read enabled, the same control returns the thresholds on the output bus, in the same order.

A partial reset restarts the serial position and both load sequences. It leaves the thresholds and the captured mode untouched.

Top module: `almost_flag_loader`

## Requirements
- R1: While `rst` is high at a clock edge, both thresholds load `DEF_LO` (7) if `dflt_sel` is 0, or `DEF_HI` (127) if it is 1. In the same edge `ae_flag` becomes 1, `af_flag` becomes 0 and `rd_vld` becomes 0.
- R2: `fwft_mode` takes the value of `sdi` on every clock edge where `rst` is high. It keeps that value at all other times, including through partial reset.
- R3: A clock edge with `prst` high (and `rst` low) leaves both thresholds and `fwft_mode` unchanged. It returns the serial bit position to bit 0 of the empty threshold and sends both load sequences back to the empty threshold.
- R4: With `ser_en` high and `ld` low, each clock edge stores `sdi` into one threshold bit. The order is the empty threshold's 9 bits LSB first, then the full threshold's 9 bits LSB first. After those 18 bits the position wraps to bit 0 of the empty threshold. `ser_en` has no effect while `ld` is high.
- R5: With `ld` and `wr_en` high, a clock edge writes `din[8:0]` into the empty threshold on the first such edge and into the full threshold on the next, alternating after that. `din[17:9]` is ignored.
- R6: With `ld` and `rd_en` high at a clock edge, `rd_data` presents the empty threshold (first such edge), then the full threshold (next), and so on. The value is zero-extended to 18 bits. `rd_vld` is high for exactly the cycles that follow such an edge. `rd_data` holds its value otherwise.
- R7: A clock edge with `ld` low returns both the write sequence and the read sequence to the empty threshold.
- R8: One clock after `occ` is presented, `ae_flag` is 1 exactly when `occ` is less than or equal to the empty threshold.
- R9: One clock after `occ` is presented, `af_flag` is 1 exactly when `DEPTH - occ` is less than or equal to the full threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading, read-back and flags |
| rst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| dflt_sel | input | 1 | Chooses the default thresholds at master reset |
| sdi | input | 1 | Timing-mode select during master reset; serial threshold data afterwards |
| ser_en | input | 1 | Serial load enable |
| ld | input | 1 | Parallel load / read-back enable |
| wr_en | input | 1 | Write qualifier for parallel load |
| rd_en | input | 1 | Read qualifier for read-back |
| din | input | 18 | Parallel data bus; bits 8:0 carry a threshold |
| occ | input | 11 | FIFO occupancy, 0 to DEPTH |
| rd_data | output | 18 | Threshold read-back bus |
| rd_vld | output | 1 | Read-back data valid |
| ae_flag | output | 1 | Almost-empty flag |
| af_flag | output | 1 | Almost-full flag |
| fwft_mode | output | 1 | Timing mode captured at master reset |

## Verification
Every result in this block appears one clock edge after the stimulus that causes it:

- a write or serial bit shows up in the stored threshold at that edge;
- a read-back request puts data on `rd_data` at that edge;
- the flags reflect the `occ` value and thresholds that were present at the previous edge.

The bench changes inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between the stimulus and the check. Thresholds that the bench has loaded, whether serially, in parallel or by reset default, are read back through the read-back path over two consecutive edges. Threshold comparisons are checked on both sides of each boundary.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

    // Which threshold a load or read-back sequence is pointing at.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    // Kind of update applied to the stored thresholds on one edge.
    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_SERIAL   = 2'd1,
        UPD_PARALLEL = 2'd2
    } upd_kind_e;

    function automatic ofs_sel_e sel_advance(input ofs_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    // The parallel path owns the thresholds whenever ld is high.
    function automatic upd_kind_e upd_decode(input logic ld,
                                             input logic wr_en,
                                             input logic ser_en);
        if (ld)
            return wr_en ? UPD_PARALLEL : UPD_NONE;
        return ser_en ? UPD_SERIAL : UPD_NONE;
    endfunction

endpackage

// File: rtl/aflag_ofs_store.sv
module aflag_ofs_store
    import aflag_pkg::*;
#(
    parameter int OFS_W  = 9,
    parameter int DEF_LO = 7,
    parameter int DEF_HI = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prst,
    input  logic             dflt_sel,
    input  logic             sdi,
    input  logic             ser_en,
    input  logic             ld,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] din_ofs,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             fwft_mode
);

    localparam int SER_BITS = 2 * OFS_W;
    localparam int SER_IW   = $clog2(SER_BITS);
    localparam logic [OFS_W-1:0] DLO = OFS_W'(DEF_LO);
    localparam logic [OFS_W-1:0] DHI = OFS_W'(DEF_HI);
    localparam logic [SER_IW-1:0] SER_LAST = SER_IW'(SER_BITS - 1);

    logic [SER_IW-1:0]   ser_idx;
    logic [SER_BITS-1:0] ser_hot;
    logic [OFS_W-1:0]    ae_ser_nx;
    logic [OFS_W-1:0]    af_ser_nx;
    ofs_sel_e            wr_sel;
    upd_kind_e           upd;

    assign upd     = upd_decode(ld, wr_en, ser_en);
    assign ser_hot = SER_BITS'(1) << ser_idx;

    // Steer the serial bit into the one bit picked by the hot mask.
    assign ae_ser_nx = (ae_ofs & ~ser_hot[OFS_W-1:0]) |
                       ({OFS_W{sdi}} & ser_hot[OFS_W-1:0]);
    assign af_ser_nx = (af_ofs & ~ser_hot[SER_BITS-1:OFS_W]) |
                       ({OFS_W{sdi}} & ser_hot[SER_BITS-1:OFS_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_ofs    <= dflt_sel ? DHI : DLO;
            af_ofs    <= dflt_sel ? DHI : DLO;
            fwft_mode <= sdi;
            ser_idx   <= '0;
            wr_sel    <= SEL_AE;
        end else if (prst) begin
            ser_idx   <= '0;
            wr_sel    <= SEL_AE;
        end else begin
            case (upd)
                UPD_SERIAL: begin
                    ae_ofs  <= ae_ser_nx;
                    af_ofs  <= af_ser_nx;
                    ser_idx <= (ser_idx == SER_LAST) ? '0 : ser_idx + 1'b1;
                end
                UPD_PARALLEL: begin
                    if (wr_sel == SEL_AE)
                        ae_ofs <= din_ofs;
                    else
                        af_ofs <= din_ofs;
                    wr_sel <= sel_advance(wr_sel);
                end
                default: ;
            endcase
            if (!ld)
                wr_sel <= SEL_AE;
        end
    end

    // R1: reset loads the chosen default into both thresholds
    a_r1_reset_default: assert property (@(posedge clk)
        rst |=> (ae_ofs == ($past(dflt_sel) ? DHI : DLO)) &&
                (af_ofs == ($past(dflt_sel) ? DHI : DLO)));

    // R2: the captured mode is frozen outside master reset
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(fwft_mode));

    // R3: partial reset never disturbs the thresholds
    a_r3_prst_keeps: assert property (@(posedge clk) disable iff (rst)
        prst |=> $stable(ae_ofs) && $stable(af_ofs));

    // R4: a serial step touches at most one threshold bit
    a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
        (ser_en && !ld && !prst) |=>
            ($countones({ae_ofs, af_ofs} ^ $past({ae_ofs, af_ofs})) <= 1));

    // R7: a cycle with ld low sends the write sequence home
    a_r7_wr_home: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (wr_sel == SEL_AE));

endmodule

// File: rtl/aflag_readback.sv
module aflag_readback
    import aflag_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prst,
    input  logic              ld,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);

    ofs_sel_e   rd_sel;
    logic       rd_req;
    logic [OFS_W-1:0] pick;

    assign rd_req = ld && rd_en;
    assign pick   = (rd_sel == SEL_AE) ? ae_ofs : af_ofs;

    always_ff @(posedge clk) begin
        if (rst || prst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
            rd_sel  <= SEL_AE;
        end else begin
            rd_vld <= rd_req;
            if (rd_req) begin
                rd_data <= DATA_W'(pick);
                rd_sel  <= sel_advance(rd_sel);
            end
            if (!ld)
                rd_sel <= SEL_AE;
        end
    end

    // R6: the bus holds its value when no read-back is requested
    a_r6_hold: assert property (@(posedge clk) disable iff (rst || prst)
        !rd_req |=> $stable(rd_data));

    // R6: the valid flag follows a request by exactly one edge
    a_r6_vld_follows: assert property (@(posedge clk) disable iff (rst || prst)
        rd_req |=> rd_vld);

    // R7: a cycle with ld low sends the read sequence home
    a_r7_rd_home: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (rd_sel == SEL_AE));

endmodule

// File: rtl/aflag_flag_gen.sv
module aflag_flag_gen #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11,
    parameter int OFS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] occ,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             ae_flag,
    output logic             af_flag
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_cnt;
    logic             ae_hit;
    logic             af_hit;

    assign free_cnt = DEPTH_C - occ;
    assign ae_hit   = occ <= CNT_W'(ae_ofs);
    assign af_hit   = free_cnt <= CNT_W'(af_ofs);

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_flag <= 1'b1;
            af_flag <= 1'b0;
        end else begin
            ae_flag <= ae_hit;
            af_flag <= af_hit;
        end
    end

    // R8: an empty FIFO always reads as almost empty
    a_r8_empty_flagged: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |=> ae_flag);

    // R9: a full FIFO always reads as almost full
    a_r9_full_flagged: assert property (@(posedge clk) disable iff (rst)
        (occ == DEPTH_C) |=> af_flag);

endmodule

// File: rtl/almost_flag_loader.sv
module almost_flag_loader #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 1024,
    parameter int DEF_LO = 7,
    parameter int DEF_HI = 127
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prst,
    input  logic                        dflt_sel,
    input  logic                        sdi,
    input  logic                        ser_en,
    input  logic                        ld,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [DATA_W-1:0]           din,
    input  logic [$clog2(DEPTH):0]      occ,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_vld,
    output logic                        ae_flag,
    output logic                        af_flag,
    output logic                        fwft_mode
);

    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int OFS_W = $clog2(DEPTH / 2);

    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    logic             unused_din_hi;

    assign unused_din_hi = ^din[DATA_W-1:OFS_W];

    aflag_ofs_store #(
        .OFS_W  (OFS_W),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .prst      (prst),
        .dflt_sel  (dflt_sel),
        .sdi       (sdi),
        .ser_en    (ser_en),
        .ld        (ld),
        .wr_en     (wr_en),
        .din_ofs   (din[OFS_W-1:0]),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .fwft_mode (fwft_mode)
    );

    aflag_readback #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_readback (
        .clk     (clk),
        .rst     (rst),
        .prst    (prst),
        .ld      (ld),
        .rd_en   (rd_en),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    aflag_flag_gen #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .OFS_W (OFS_W)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .occ     (occ),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .ae_flag (ae_flag),
        .af_flag (af_flag)
    );

    // R8 R9: thresholds below half depth make both flags mutually exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ae_flag && af_flag));

endmodule

// File: tb/tb_almost_flag_loader.sv
`timescale 1ns/1ps
module tb_almost_flag_loader;

    localparam int DATA_W = 18;
    localparam int DEPTH  = 1024;
    localparam int CNT_W  = 11;

    logic              clk = 1'b0;
    logic              rst, prst, dflt_sel, sdi, ser_en, ld, wr_en, rd_en;
    logic [DATA_W-1:0] din;
    logic [CNT_W-1:0]  occ;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld, ae_flag, af_flag, fwft_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    almost_flag_loader dut (
        .clk(clk), .rst(rst), .prst(prst), .dflt_sel(dflt_sel), .sdi(sdi),
        .ser_en(ser_en), .ld(ld), .wr_en(wr_en), .rd_en(rd_en), .din(din),
        .occ(occ), .rd_data(rd_data), .rd_vld(rd_vld), .ae_flag(ae_flag),
        .af_flag(af_flag), .fwft_mode(fwft_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rst = 0; prst = 0; ser_en = 0; ld = 0; wr_en = 0; rd_en = 0; sdi = 0;
        din = '0;
    endtask

    // Reads both thresholds through the read-back path (R6 ordering).
    task automatic read_pair(output logic [DATA_W-1:0] ae_v,
                             output logic [DATA_W-1:0] af_v);
        ld = 1; rd_en = 1;
        step(); ae_v = rd_data;
        step(); af_v = rd_data;
        ld = 0; rd_en = 0;
        step();
    endtask

    task automatic par_write(input logic [DATA_W-1:0] v);
        ld = 1; wr_en = 1; din = v;
        step();
    endtask

    task automatic shift_bits(input logic [8:0] v);
        for (int i = 0; i < 9; i++) begin
            ser_en = 1; sdi = v[i];
            step();
        end
        ser_en = 0; sdi = 0;
    endtask

    task automatic t_reset(input logic sel, input logic mode);
        logic [DATA_W-1:0] a, f;
        logic [31:0] dv;
        dv = sel ? 127 : 7;
        idle_inputs();
        rst = 1; dflt_sel = sel; sdi = mode;
        step(); step();
        chk("R1", "ae_flag in reset", ae_flag, 1);
        chk("R1", "af_flag in reset", af_flag, 0);
        chk("R1", "rd_vld in reset", rd_vld, 0);
        chk("R2", "mode capture", fwft_mode, mode);
        rst = 0; sdi = ~mode; occ = 11'd500;
        step();
        chk("R2", "mode held after sdi change", fwft_mode, mode);
        read_pair(a, f);
        chk("R1", "ae default", a, dv);
        chk("R1", "af default", f, dv);
    endtask

    task automatic t_parallel();
        logic [DATA_W-1:0] a, f;
        par_write(18'h3FC05);
        par_write(18'h2A1F0);
        ld = 0; wr_en = 0;
        step();
        read_pair(a, f);
        chk("R5", "ae parallel, upper bits ignored", a, 5);
        chk("R5", "af parallel, upper bits ignored", f, 32'h1F0);
        ld = 1; rd_en = 1;
        step();
        ld = 0; rd_en = 0;
        step();
        chk("R6", "rd_vld low after request ends", rd_vld, 0);
        chk("R6", "rd_data holds", rd_data, 5);
    endtask

    task automatic t_ptr_home();
        logic [DATA_W-1:0] a, f;
        par_write(18'd33);
        ld = 0; wr_en = 0;
        step();
        par_write(18'd44);
        ld = 0; wr_en = 0;
        step();
        read_pair(a, f);
        chk("R7", "write sequence restarts at ae", a, 44);
        chk("R7", "af untouched", f, 32'h1F0);
        ld = 1; rd_en = 1;
        step();
        ld = 0; rd_en = 0;
        step();
        ld = 1; rd_en = 1;
        step();
        chk("R7", "read sequence restarts at ae", rd_data, 44);
        ld = 0; rd_en = 0;
        step();
    endtask

    task automatic t_serial();
        logic [DATA_W-1:0] a, f;
        shift_bits(9'h0A5);
        shift_bits(9'h13C);
        read_pair(a, f);
        chk("R4", "ae serial LSB first", a, 32'h0A5);
        chk("R4", "af serial LSB first", f, 32'h13C);
        ld = 1; ser_en = 1; sdi = 1;
        step(); step(); step();
        ld = 0; ser_en = 0; sdi = 0;
        step();
        read_pair(a, f);
        chk("R4", "ser_en ignored under ld (ae)", a, 32'h0A5);
        chk("R4", "ser_en ignored under ld (af)", f, 32'h13C);
        ser_en = 1; sdi = 0;
        step();
        ser_en = 0;
        step();
        read_pair(a, f);
        chk("R4", "wrap to ae bit0", a, 32'h0A4);
    endtask

    task automatic t_prst();
        logic [DATA_W-1:0] a, f;
        logic m;
        m = fwft_mode;
        prst = 1; sdi = ~m;
        step();
        prst = 0; sdi = 0;
        step();
        chk("R3", "mode kept", fwft_mode, m);
        read_pair(a, f);
        chk("R3", "ae kept", a, 32'h0A4);
        chk("R3", "af kept", f, 32'h13C);
        shift_bits(9'd3);
        read_pair(a, f);
        chk("R3", "serial position restarted", a, 3);
        chk("R3", "af not touched by restarted shift", f, 32'h13C);
    endtask

    task automatic t_flags();
        par_write(18'd10);
        par_write(18'd20);
        ld = 0; wr_en = 0;
        occ = 11'd10;   step();
        chk("R8", "ae at occ==ofs", ae_flag, 1);
        occ = 11'd11;   step();
        chk("R8", "ae at occ==ofs+1", ae_flag, 0);
        occ = 11'd0;    step();
        chk("R8", "ae at empty", ae_flag, 1);
        occ = 11'd1004; step();
        chk("R9", "af at free==ofs", af_flag, 1);
        chk("R8", "ae low near full", ae_flag, 0);
        occ = 11'd1003; step();
        chk("R9", "af at free==ofs+1", af_flag, 0);
        occ = 11'd1024; step();
        chk("R9", "af at full", af_flag, 1);
    endtask

    initial begin
        idle_inputs();
        rst = 1; dflt_sel = 0; occ = '0;
        t_reset(1'b0, 1'b1);
        t_reset(1'b1, 1'b0);
        t_parallel();
        t_ptr_home();
        t_serial();
        t_prst();
        t_flags();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule